// File: doc/BRIEF.md
# Receive Character Buffer with Error Status

This block sits between a serial receiver and a host. Each received character arrives on the write side as a byte with three error flags: parity error, framing error and break. It is stored as one entry in a first-in first-out buffer that holds `DEPTH` entries (8 or 16). The host always sees the oldest entry on `top_data`. Pulsing `pop` for one cycle discards that entry, so the next one moves to the top. Overrun is kept as one sticky flag outside the buffer and is not stored per entry.

The host sees receiver-ready, buffer-full and overrun status. It also sees three error outputs whose meaning depends on `err_mode`. With `err_mode` low, they give the flags of the top entry only, so the host reads status before popping. With `err_mode` high, they give the OR of each flag over all characters accepted since the last `err_clr` pulse. An interrupt request follows either ready or full, as chosen by `irq_sel`.

Occupancy is held by a three-state machine with a counter:
- `OCC_EMPTY` moves to `OCC_PARTIAL` on an accepted write.
- `OCC_PARTIAL` moves to `OCC_FULL` when a write without a pop fills the last slot.
- `OCC_PARTIAL` moves to `OCC_EMPTY` when a pop without a write takes the last entry.
- `OCC_FULL` moves to `OCC_PARTIAL` on a pop without a write.
- Every other case holds the current state.

Top module: `rx_status_fifo`

## Requirements
- R1: `rx_ready` is high exactly when at least one entry is stored. It updates on the clock edge that accepts a write or performs a pop.
- R2: `rx_full` is high exactly when `DEPTH` entries are stored.
- R3: Entries leave in the order they were written. `top_data` shows the byte of the oldest entry while `rx_ready` is high. A `pop` while not empty removes that entry.
- R4: A write (`wr_en`) while full and without `pop` is discarded. The stored entries stay unchanged and `overrun` goes high on that edge.
- R5: A write together with `pop` while full performs both. The buffer stays full and `overrun` is not set by it. A write together with `pop` while empty stores the write and ignores the pop.
- R6: `pop` while empty and without a write has no effect. `rx_ready` stays low.
- R7: With `err_mode`=0, `err_par`, `err_frm` and `err_brk` equal the parity, framing and break flags written with the top entry.
- R8: With `err_mode`=1, each error output is the OR of that flag over every accepted write since the last `err_clr` or reset. Discarded writes do not count.
- R9: `err_clr` clears the accumulated flags and `overrun`. A write accepted in the same cycle still adds its flags. A discarded write in the same cycle still sets `overrun`.
- R10: While `rx_ready` is low, `err_par`, `err_frm` and `err_brk` are 0 in both modes.
- R11: `irq` follows `rx_ready` when `irq_sel`=0 and follows `rx_full` when `irq_sel`=1.
- R12: After reset the buffer is empty and `rx_ready`, `rx_full`, `overrun`, `irq` and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character valid from receiver |
| wr_data | input | 8 | Received byte |
| wr_par | input | 1 | Parity error flag of the byte |
| wr_frm | input | 1 | Framing error flag of the byte |
| wr_brk | input | 1 | Break flag of the byte |
| pop | input | 1 | Host removes the top entry |
| err_mode | input | 1 | 0: per-character flags, 1: accumulated flags |
| irq_sel | input | 1 | 0: interrupt on ready, 1: interrupt on full |
| err_clr | input | 1 | Clears accumulated flags and overrun |
| top_data | output | 8 | Byte of the oldest entry |
| rx_ready | output | 1 | At least one entry stored |
| rx_full | output | 1 | All entries occupied |
| overrun | output | 1 | A write was lost since the last clear |
| err_par | output | 1 | Reported parity error |
| err_frm | output | 1 | Reported framing error |
| err_brk | output | 1 | Reported break |
| irq | output | 1 | Interrupt request |

## Verification
Every write, pop and clear takes effect on the next rising edge. All outputs are driven from registers through combinational logic only, so every result is due one edge after its stimulus. The only exceptions are `err_mode` and `irq_sel`, which change the error and interrupt outputs within the same cycle. The bench drives inputs one time unit after an edge. It updates its reference model at the next edge and compares every output one time unit later, so each check lands in the cycle right after the edge that should have produced the result.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rsf_flags_t;

    typedef struct packed {
        rsf_flags_t          flags;
        logic [BYTE_W-1:0]   data;
    } rsf_entry_t;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/rsf_occ_fsm.sv
module rsf_occ_fsm
    import rsf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_req,
    output logic push,
    output logic pull,
    output logic lost,
    output logic not_empty,
    output logic is_full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    occ_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state and count
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (push) state_nxt = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push && !pull && cnt == CNT_LAST)
                    state_nxt = OCC_FULL;
                else if (pull && !push && cnt == CNT_ONE)
                    state_nxt = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pull && !push) state_nxt = OCC_PARTIAL;
            end
            default: state_nxt = OCC_EMPTY;
        endcase

        unique case ({push, pull})
            2'b10:   cnt_nxt = cnt + CNT_ONE;
            2'b01:   cnt_nxt = cnt - CNT_ONE;
            default: cnt_nxt = cnt;
        endcase
    end

    // outputs
    always_comb begin
        push      = 1'b0;
        pull      = 1'b0;
        lost      = 1'b0;
        not_empty = 1'b0;
        is_full   = 1'b0;
        unique case (state)
            OCC_EMPTY: begin
                push = wr_req;
            end
            OCC_PARTIAL: begin
                push      = wr_req;
                pull      = rd_req;
                not_empty = 1'b1;
            end
            OCC_FULL: begin
                pull      = rd_req;
                push      = wr_req && rd_req;
                lost      = wr_req && !rd_req;
                not_empty = 1'b1;
                is_full   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rsf_store.sv
module rsf_store
    import rsf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pull,
    input  rsf_entry_t wr_entry,
    output rsf_entry_t top_entry
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);

    rsf_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] head, tail;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_END) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (push) tail <= advance(tail);
            if (pull) head <= advance(head);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && tail == PTR_W'(i)) slots[i] <= wr_entry;
        end
    end

    assign top_entry = slots[head];
endmodule

// File: rtl/rsf_flag_acc.sv
module rsf_flag_acc
    import rsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic       lost,
    input  rsf_flags_t wr_flags,
    output rsf_flags_t acc_flags,
    output logic       ovr
);
    rsf_flags_t base;

    always_comb base = clr ? rsf_flags_t'('0) : acc_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_flags <= '0;
            ovr       <= 1'b0;
        end else begin
            acc_flags <= push ? (base | wr_flags) : base;
            ovr       <= (ovr && !clr) || lost;
        end
    end
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rsf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              wr_frm,
    input  logic              wr_brk,
    input  logic              pop,
    input  logic              err_mode,
    input  logic              irq_sel,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] top_data,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              overrun,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_brk,
    output logic              irq
);
    logic       push, pull, lost;
    rsf_entry_t wr_entry, top_entry;
    rsf_flags_t acc_flags, shown;

    assign wr_entry.data      = wr_data;
    assign wr_entry.flags.par = wr_par;
    assign wr_entry.flags.frm = wr_frm;
    assign wr_entry.flags.brk = wr_brk;

    rsf_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .rd_req    (pop),
        .push      (push),
        .pull      (pull),
        .lost      (lost),
        .not_empty (rx_ready),
        .is_full   (rx_full)
    );

    rsf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pull      (pull),
        .wr_entry  (wr_entry),
        .top_entry (top_entry)
    );

    rsf_flag_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (err_clr),
        .push      (push),
        .lost      (lost),
        .wr_flags  (wr_entry.flags),
        .acc_flags (acc_flags),
        .ovr       (overrun)
    );

    always_comb begin
        if (!rx_ready)     shown = '0;
        else if (err_mode) shown = acc_flags;
        else               shown = top_entry.flags;
    end

    assign top_data = top_entry.data;
    assign err_par  = shown.par;
    assign err_frm  = shown.frm;
    assign err_brk  = shown.brk;
    assign irq      = irq_sel ? rx_full : rx_ready;
endmodule

// File: rtl/rsf_chk.sv
module rsf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       pop,
    input logic       err_clr,
    input logic [7:0] top_data,
    input logic       rx_ready,
    input logic       rx_full,
    input logic       overrun,
    input logic       err_par,
    input logic       err_frm,
    input logic       err_brk,
    input logic       irq
);
    // R2
    full_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_ready);

    // R4
    lost_write_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rx_full && !pop) |=> overrun);

    // R4
    lost_write_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rx_full && !pop) |=> (rx_full && $stable(top_data)));

    // R5
    full_swap_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rx_full && pop) |=> rx_full);

    // R6
    empty_pop_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && pop && !wr_en) |=> !rx_ready);

    // R9
    clear_drops_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(wr_en && rx_full && !pop)) |=> !overrun);

    // R10
    flags_need_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> !(err_par || err_frm || err_brk));

    // R11
    irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> !irq);
endmodule

bind rx_status_fifo rsf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .pop      (pop),
    .err_clr  (err_clr),
    .top_data (top_data),
    .rx_ready (rx_ready),
    .rx_full  (rx_full),
    .overrun  (overrun),
    .err_par  (err_par),
    .err_frm  (err_frm),
    .err_brk  (err_brk),
    .irq      (irq)
);

// File: tb/sim_rx_status_fifo.sv
module sim_rx_status_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_par, wr_frm, wr_brk, pop, err_mode, irq_sel, err_clr;
    logic [7:0] wr_data;
    logic [7:0] top_data;
    logic       rx_ready, rx_full, overrun, err_par, err_frm, err_brk, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state: entry = {brk, frm, par, data}
    logic [10:0] mq[$];
    logic [2:0]  m_acc;
    logic        m_ovr;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_status_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk), .pop(pop),
        .err_mode(err_mode), .irq_sel(irq_sel), .err_clr(err_clr),
        .top_data(top_data), .rx_ready(rx_ready), .rx_full(rx_full),
        .overrun(overrun), .err_par(err_par), .err_frm(err_frm),
        .err_brk(err_brk), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_flags();
        if (mq.size() == 0) return 3'b000;
        if (err_mode)       return m_acc;
        return mq[0][10:8];
    endfunction

    task automatic compare_all();
        logic rdy, ful;
        rdy = (mq.size() != 0);
        ful = (mq.size() == DEPTH);
        check("R1 rx_ready", rx_ready, rdy);
        check("R2 rx_full", rx_full, ful);
        if (rdy) check("R3 top_data", top_data, mq[0][7:0]);
        check("R4/R9 overrun", overrun, m_ovr);
        if (!rdy) check("R10 flags when empty", {err_brk, err_frm, err_par}, 3'b000);
        else if (err_mode) check("R8 block flags", {err_brk, err_frm, err_par}, exp_flags());
        else check("R7 char flags", {err_brk, err_frm, err_par}, exp_flags());
        check("R11 irq", irq, irq_sel ? ful : rdy);
    endtask

    // drive one cycle; called one time unit after an edge
    task automatic step(input logic w, input logic [7:0] d, input logic [2:0] f,
                        input logic r, input logic c);
        logic full_b, empty_b, do_pop, do_push, do_lost;
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = f; pop = r; err_clr = c;
        @(posedge clk);
        full_b  = (mq.size() == DEPTH);
        empty_b = (mq.size() == 0);
        do_pop  = r && !empty_b;
        do_push = w && (!full_b || r);
        do_lost = w && full_b && !r;
        m_acc = (c ? 3'b000 : m_acc) | (do_push ? f : 3'b000);
        m_ovr = (c ? 1'b0 : m_ovr) | do_lost;
        if (do_pop)  void'(mq.pop_front());
        if (do_push) mq.push_back({f, d});
        #1;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        wr_en = 0; wr_data = 0; wr_par = 0; wr_frm = 0; wr_brk = 0;
        pop = 0; err_mode = 0; irq_sel = 0; err_clr = 0;
        m_acc = 3'b000; m_ovr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 ready", rx_ready, 1'b0);
        check("R12 full", rx_full, 1'b0);
        check("R12 overrun", overrun, 1'b0);
        check("R12 irq", irq, 1'b0);
        check("R12 flags", {err_brk, err_frm, err_par}, 3'b000);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R6: pop on empty
        step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        // R5: write plus pop on empty keeps the write
        step(1'b1, 8'hA5, 3'b001, 1'b1, 1'b0);
        step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);

        // fill to full, per-character flags, irq on full (R2, R11)
        irq_sel = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 8'(8'h10 + i), 3'(i % 8), 1'b0, 1'b0);
        check("R2 full after fill", rx_full, 1'b1);
        // R4: lost write
        step(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0);
        check("R4 overrun set", overrun, 1'b1);
        check("R4 top kept", top_data, 8'h10);
        // R5: swap while full
        step(1'b1, 8'h77, 3'b100, 1'b1, 1'b0);
        check("R5 still full", rx_full, 1'b1);
        // R9: clear with a lost write in the same cycle keeps overrun
        step(1'b1, 8'h66, 3'b010, 1'b0, 1'b1);
        check("R9 overrun relatched", overrun, 1'b1);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R9 overrun cleared", overrun, 1'b0);

        // drain in character mode, then block mode (R3, R7, R8)
        irq_sel = 1'b0;
        for (int i = 0; i < DEPTH / 2; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        err_mode = 1'b1;
        #1 compare_all();
        for (int i = 0; i < DEPTH / 2; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        check("R1 empty after drain", rx_ready, 1'b0);

        // R9: clear with an accepted write keeps its flags
        step(1'b1, 8'h3C, 3'b001, 1'b0, 1'b0);
        step(1'b1, 8'h3D, 3'b100, 1'b0, 1'b1);
        check("R9 accepted flag kept", {err_brk, err_frm, err_par}, 3'b100);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            if (n % 400 == 0) begin
                err_mode = 1'($urandom_range(1));
                irq_sel  = 1'($urandom_range(1));
            end
            step(($urandom_range(99) < 55), 8'($urandom),
                 {($urandom_range(3) == 0), ($urandom_range(3) == 0), ($urandom_range(3) == 0)},
                 ($urandom_range(99) < ((n / 700) % 2 == 0 ? 40 : 65)),
                 ($urandom_range(99) < 4));
        end
        finish_run();
    end
endmodule